// File: doc/BRIEF.md
# Peripheral Register Window Decoder with Endian Byte Lanes

This block sits between a simple synchronous CPU bus and the control registers of a chip's non-network peripherals. It claims a fixed 16 KB address window at 0x8000_0000. That window is cut into 64-byte slots, and each slot holds at most one register. An ordinary register answers anywhere inside its slot, because the six lowest address bits are not decoded for it. The one exception is the slot that holds the four byte-wide general-purpose I/O ports. There the lowest two address bits pick one port, so software can read or write a single port with a byte access.

The internal registers are little endian. A bus-level endian input reverses the byte address inside a word, and this decides which data lane a byte access uses. Word accesses are the same in both modes. The register bank has two reset domains. Most state is cleared by a power-on, user or power-fail reset. Three preserved registers are cleared only by power-on reset: a memory refresh period, a time-of-day count and a time alarm match. This keeps their contents through a user reset or a power-fail reset.

Read data is registered and appears one clock after the request. Writes take effect on the clock edge that samples them.

Top module: `periph_reg_decoder`

## Requirements
- R1: Only addresses 0x8000_0000 to 0x8000_3FFF select a register. Outside that range, a write changes no register and a read returns zero.
- R2: The register slot is address bits [13:6]. Bits [5:0] are ignored, so an ordinary register answers at all 64 byte addresses of its slot. This also holds for slots that border unused slots. The slot map is: GPIO slot 0, general registers in slots 1 to 4, refresh register in slot 8, time count in slot 9 and time match in slot 10.
- R3: Size code 00 means byte, 01 means half-word, and 10 or 11 means word. A byte access to slot 0 uses lane L. L is addr[1:0] when big_endian is 0, and the bitwise inverse of addr[1:0] when big_endian is 1. Port L sits on data bits [8L+7:8L]. A byte write updates only port L, taking it from that lane. A byte read returns port L in that lane and zero in the other lanes.
- R4: A word access to slot 0 writes or reads all four ports at once, and the result does not depend on big_endian.
- R5: A half-word access to slot 0 does not change any port and returns zero read data. It also raises size_err for exactly the cycle in which that access's read data is presented.
- R6: Ordinary registers ignore the access size and big_endian. A read of any size returns the whole register, and a write of any size loads the register from the whole write data word.
- R7: General registers are 16 bits wide, the refresh register is 8 bits wide, and the two time registers are 32 bits wide, all right-justified. Bits above a register's width are dropped on write and read as zero. Unmapped slots read zero.
- R8: bus_rdata is valid on the clock after a read request and is zero after a write or an idle cycle. A write is visible to a read issued on the very next cycle.
- R9: While power-on reset is low at a clock edge, every register, the read data and size_err clear to zero. This holds even if other resets are low at the same time.
- R10: A user or power-fail reset with power-on reset high clears the GPIO ports, the general registers, the read data and size_err. It leaves the three preserved registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_user_n | input | 1 | User reset, active low, synchronous |
| rst_pwrfail_n | input | 1 | Power-fail reset, active low, synchronous |
| bus_req | input | 1 | Access presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | 00 byte, 01 half-word, 1x word |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| big_endian | input | 1 | Reverses byte addresses within a word |
| bus_rdata | output | 32 | Registered read data |
| size_err | output | 1 | One-cycle flag for a half-word access to the GPIO slot |

## Verification
The bench sweeps every byte offset of the first sixteen slots with every access size in both endian modes. This catches a decoder that uses the low address bits for ordinary registers, or one that drops aliasing next to the unused slots. Byte writes to each port in both modes show whether the lane reversal is missing or applied to word accesses, which would corrupt the wrong port. Addresses that differ from the window only in high bits would land on a live register if the window compare were too narrow. Reset sequences in every combination show a preserved register that is wrongly wiped by a user or power-fail reset, and they show a power-on reset that fails to win over the others.

// File: rtl/regdec_pkg.sv
// Shared definitions for the peripheral register window decoder.
// Assumes a 32-bit data bus with four byte lanes.
package regdec_pkg;

    // Access size codes as driven on the bus
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    // Byte lane addressed by the two low address bits under the endian mode
    function automatic logic [1:0] byte_lane(input logic [1:0] addr_lo, input logic big_end);
        return big_end ? ~addr_lo : addr_lo;
    endfunction

endpackage

// File: rtl/regdec_addr_decode.sv
// Address decoder: checks the window, extracts the 64-byte slot index and
// computes the endian-adjusted byte lane. Purely combinational.
// Assumes BASE is aligned to 2**WIN_BITS.
module regdec_addr_decode
    import regdec_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE      = 32'h8000_0000,
    parameter int          WIN_BITS  = 14,
    parameter int          SLOT_BITS = 6,
    parameter int          GPIO_SLOT = 0,
    localparam int         SLOT_W    = WIN_BITS - SLOT_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              big_endian,
    output logic              in_win,
    output logic              gpio_sel,
    output logic [SLOT_W-1:0] slot,
    output logic [1:0]        lane
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    // Window match on the high bits, slot index and lane extraction
    always_comb begin
        in_win   = (addr[ADDR_W-1:WIN_BITS] == BASE_A[ADDR_W-1:WIN_BITS]);
        slot     = addr[WIN_BITS-1:SLOT_BITS];
        gpio_sel = in_win && (slot == SLOT_W'(GPIO_SLOT));
        lane     = byte_lane(addr[1:0], big_endian);
    end

endmodule

// File: rtl/regdec_gpio_bank.sv
// Four byte-wide port registers that accept word writes, or byte writes
// into one port selected by lane. Cleared by the general reset domain.
// Assumes the caller has already filtered out half-word accesses.
module regdec_gpio_bank #(
    parameter int DATA_W = 32,
    localparam int PORTS = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_clr_n,
    input  logic              we_word,
    input  logic              we_byte,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ports
);
    logic [7:0] port_q [PORTS];

    for (genvar k = 0; k < PORTS; k++) begin : g_port
        // Load port k on a word write or a byte write aimed at its lane
        always_ff @(posedge clk) begin
            if (!rst_clr_n)
                port_q[k] <= '0;
            else if (we_word || (we_byte && lane == 2'(k)))
                port_q[k] <= wdata[8*k +: 8];
        end

        assign ports[8*k +: 8] = port_q[k];

        // R3
        other_port_stable_chk: assert property (@(posedge clk) disable iff (!rst_clr_n)
            (we_byte && !we_word && lane != 2'(k)) |=> $stable(port_q[k]))
            else $error("byte write disturbed port %0d", k);
    end

endmodule

// File: rtl/regdec_reg_bank.sv
// Ordinary register bank: general registers in the full reset domain and
// preserved registers cleared only by power-on reset. Writes load the whole
// data word truncated to the register width; reads zero-extend.
// Assumes slot indices in the parameters are distinct and not the GPIO slot.
module regdec_reg_bank #(
    parameter int                 DATA_W        = 32,
    parameter int                 SLOT_W        = 8,
    parameter int                 GEN_COUNT     = 4,
    parameter int                 GEN_W         = 16,
    parameter int                 GEN_BASE_SLOT = 1,
    parameter int                 PRES_COUNT    = 3,
    parameter logic [PRES_COUNT*8-1:0] PRES_SLOTS = {8'd10, 8'd9, 8'd8},
    parameter logic [PRES_COUNT*8-1:0] PRES_WIDTHS = {8'd32, 8'd32, 8'd8}
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_clr_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    logic [GEN_W-1:0]  gen_q  [GEN_COUNT];
    logic [DATA_W-1:0] pres_q [PRES_COUNT];
    logic [DATA_W-1:0] gen_rd [GEN_COUNT];
    logic [DATA_W-1:0] pres_rd[PRES_COUNT];

    for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(GEN_BASE_SLOT + g);

        // General register: cleared by any system reset
        always_ff @(posedge clk) begin
            if (!rst_clr_n)
                gen_q[g] <= '0;
            else if (we && slot == MY_SLOT)
                gen_q[g] <= wdata[GEN_W-1:0];
        end

        assign gen_rd[g] = (slot == MY_SLOT) ? DATA_W'(gen_q[g]) : '0;
    end

    for (genvar p = 0; p < PRES_COUNT; p++) begin : g_pres
        localparam int                W       = int'(PRES_WIDTHS[p*8 +: 8]);
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(PRES_SLOTS[p*8 +: 8]);
        localparam logic [DATA_W-1:0] MASK    = DATA_W'((64'd1 << W) - 64'd1);

        // Preserved register: cleared by power-on reset only
        always_ff @(posedge clk) begin
            if (!rst_por_n)
                pres_q[p] <= '0;
            else if (we && slot == MY_SLOT)
                pres_q[p] <= wdata & MASK;
        end

        assign pres_rd[p] = (slot == MY_SLOT) ? pres_q[p] : '0;

        // R10
        pres_keep_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
            (!rst_clr_n && !(we && slot == MY_SLOT)) |=> $stable(pres_q[p]))
            else $error("preserved register %0d lost on non-power-on reset", p);
    end

    // Merge the per-register read values; unmapped slots give zero
    always_comb begin
        rd_val = '0;
        for (int g = 0; g < GEN_COUNT; g++)  rd_val |= gen_rd[g];
        for (int p = 0; p < PRES_COUNT; p++) rd_val |= pres_rd[p];
    end

endmodule

// File: rtl/periph_reg_decoder.sv
// Top of the peripheral register window decoder. Decodes each bus access,
// steers writes to the GPIO or ordinary register bank, builds the registered
// read data and flags half-word GPIO accesses. Resets are synchronous and
// active low; power-on reset dominates the general clear.
// Assumes one access per cycle and a 32-bit data bus.
module periph_reg_decoder
    import regdec_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] BASE      = 32'h8000_0000,
    parameter int          WIN_BITS  = 14,
    parameter int          SLOT_BITS = 6,
    parameter int          GPIO_SLOT = 0,
    parameter int          GEN_COUNT = 4,
    parameter int          GEN_W     = 16,
    localparam int         SLOT_W    = WIN_BITS - SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_user_n,
    input  logic              rst_pwrfail_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              big_endian,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              size_err
);
    logic              rst_clr_n;
    logic              in_win, gpio_sel;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        lane;
    logic              is_byte, is_half;
    logic              gpio_we_word, gpio_we_byte, gpio_half, reg_we;
    logic [DATA_W-1:0] gpio_ports, bank_val, rd_next;

    assign rst_clr_n = rst_por_n & rst_user_n & rst_pwrfail_n;

    regdec_addr_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .WIN_BITS(WIN_BITS),
        .SLOT_BITS(SLOT_BITS), .GPIO_SLOT(GPIO_SLOT)
    ) u_dec (
        .addr(bus_addr), .big_endian(big_endian),
        .in_win(in_win), .gpio_sel(gpio_sel), .slot(slot), .lane(lane)
    );

    // Classify the access and produce the per-bank write strobes
    always_comb begin
        is_byte      = (bus_size == SZ_BYTE);
        is_half      = (bus_size == SZ_HALF);
        gpio_half    = bus_req && gpio_sel && is_half;
        gpio_we_word = bus_req && bus_wr && gpio_sel && !is_byte && !is_half;
        gpio_we_byte = bus_req && bus_wr && gpio_sel && is_byte;
        reg_we       = bus_req && bus_wr && in_win && !gpio_sel;
    end

    regdec_gpio_bank #(.DATA_W(DATA_W)) u_gpio (
        .clk(clk), .rst_clr_n(rst_clr_n),
        .we_word(gpio_we_word), .we_byte(gpio_we_byte), .lane(lane),
        .wdata(bus_wdata), .ports(gpio_ports)
    );

    regdec_reg_bank #(
        .DATA_W(DATA_W), .SLOT_W(SLOT_W), .GEN_COUNT(GEN_COUNT),
        .GEN_W(GEN_W), .GEN_BASE_SLOT(GPIO_SLOT + 1)
    ) u_bank (
        .clk(clk), .rst_por_n(rst_por_n), .rst_clr_n(rst_clr_n),
        .we(reg_we), .slot(slot), .wdata(bus_wdata), .rd_val(bank_val)
    );

    // Select next read data: GPIO lane view, ordinary register or zero
    always_comb begin
        rd_next = '0;
        if (bus_req && !bus_wr && in_win) begin
            if (gpio_sel) begin
                if (is_byte)
                    rd_next[8*lane +: 8] = gpio_ports[8*lane +: 8];
                else if (!is_half)
                    rd_next = gpio_ports;
            end else begin
                rd_next = bank_val;
            end
        end
    end

    // Register read data and the size error flag
    always_ff @(posedge clk) begin
        if (!rst_clr_n) begin
            bus_rdata <= '0;
            size_err  <= 1'b0;
        end else begin
            bus_rdata <= rd_next;
            size_err  <= gpio_half;
        end
    end

    // R1
    out_of_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_clr_n)
        (bus_req && !bus_wr && !in_win) |=> (bus_rdata == '0))
        else $error("read outside window returned data");

    // R5
    half_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_clr_n)
        (bus_req && bus_wr && gpio_sel && is_half) |=> $stable(gpio_ports))
        else $error("half-word write changed a port");

    // R5
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_clr_n)
        size_err |-> (bus_rdata == '0))
        else $error("size error with nonzero read data");

endmodule

// File: tb/periph_reg_decoder_bench.sv
// Self-checking bench: sweeps slots, offsets, sizes and endian modes against
// a model computed from the requirements, plus reset-domain sequences.
module periph_reg_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0, rst_user_n = 1'b1, rst_pwrfail_n = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0, big_endian = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_rdata;
    logic        size_err;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0]  m_gpio [4];
    logic [15:0] m_gen  [4];
    logic [31:0] m_pres [3];

    always #10 clk = ~clk;

    periph_reg_decoder u_periph_reg_decoder (
        .clk(clk), .rst_por_n(rst_por_n), .rst_user_n(rst_user_n),
        .rst_pwrfail_n(rst_pwrfail_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .big_endian(big_endian), .bus_rdata(bus_rdata), .size_err(size_err)
    );

    function automatic bit in_win(input logic [31:0] a);
        return a[31:14] == 18'h20000;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic [1:0] sz);
        logic [1:0] ln;
        logic [31:0] r;
        r = '0;
        if (!in_win(a)) return r;
        ln = big_endian ? ~a[1:0] : a[1:0];
        case (a[13:6])
            8'd0: begin
                if (sz == 2'b00) r[8*ln +: 8] = m_gpio[ln];
                else if (sz != 2'b01) r = {m_gpio[3], m_gpio[2], m_gpio[1], m_gpio[0]};
            end
            8'd1, 8'd2, 8'd3, 8'd4: r = {16'h0, m_gen[a[13:6]-8'd1]};
            8'd8:  r = m_pres[0];
            8'd9:  r = m_pres[1];
            8'd10: r = m_pres[2];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
        logic [1:0] ln;
        if (!in_win(a)) return;
        ln = big_endian ? ~a[1:0] : a[1:0];
        case (a[13:6])
            8'd0: begin
                if (sz == 2'b00) m_gpio[ln] = wd[8*ln +: 8];
                else if (sz != 2'b01)
                    for (int k = 0; k < 4; k++) m_gpio[k] = wd[8*k +: 8];
            end
            8'd1, 8'd2, 8'd3, 8'd4: m_gen[a[13:6]-8'd1] = wd[15:0];
            8'd8:  m_pres[0] = {24'h0, wd[7:0]};
            8'd9:  m_pres[1] = wd;
            8'd10: m_pres[2] = wd;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        logic [31:0] e;
        logic        ee;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        e  = wr ? 32'h0 : exp_rd(a, sz);
        ee = in_win(a) && a[13:6] == 8'd0 && sz == 2'b01;
        check(tag, bus_rdata, e);
        check(tag, {31'h0, size_err}, {31'h0, ee});
        if (wr) model_write(a, sz, wd);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_reset(input logic por, input logic usr, input logic pf);
        @(negedge clk);
        rst_por_n = por; rst_user_n = usr; rst_pwrfail_n = pf;
        @(negedge clk);
        rst_por_n = 1'b1; rst_user_n = 1'b1; rst_pwrfail_n = 1'b1;
        if (!por) begin
            for (int k = 0; k < 4; k++) m_gpio[k] = '0;
            for (int k = 0; k < 4; k++) m_gen[k] = '0;
            for (int k = 0; k < 3; k++) m_pres[k] = '0;
        end else if (!usr || !pf) begin
            for (int k = 0; k < 4; k++) m_gpio[k] = '0;
            for (int k = 0; k < 4; k++) m_gen[k] = '0;
        end
        check("R9 R10 rdata after reset", bus_rdata, 32'h0);
        check("R9 R10 size_err after reset", {31'h0, size_err}, 32'h0);
    endtask

    task automatic fill_all();
        for (int s = 0; s < 16; s++)
            access(1'b1, 32'h8000_0000 | (s << 6) | ((s * 12) & 60), 2'b10,
                   32'h9E37_79B9 * (s + 1), "R2 R7 fill");
    endtask

    task automatic read_slots(input string tag);
        for (int s = 0; s < 16; s++)
            access(1'b0, 32'h8000_0000 | (s << 6), 2'b10, 32'h0, tag);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin m_gpio[k] = '0; m_gen[k] = '0; end
        for (int k = 0; k < 3; k++) m_pres[k] = '0;
        repeat (2) @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);
        check("R9 rdata after power-on", bus_rdata, 32'h0);
        read_slots("R9 registers zero after power-on");

        // Fill every slot, then sweep all offsets, sizes and endian modes
        fill_all();
        for (int be = 0; be < 2; be++) begin
            big_endian = be[0];
            for (int sz = 0; sz < 3; sz++)
                for (int s = 0; s < 16; s++)
                    for (int off = 0; off < 64; off++)
                        access(1'b0, 32'h8000_0000 | (s << 6) | off, 2'(sz), 32'h0,
                               s == 0 ? (sz == 0 ? "R3 byte read" : sz == 1 ? "R5 half read" : "R4 word read")
                                      : "R2 R6 R7 sweep read");
        end

        // GPIO byte writes per lane in both modes, read back by word
        for (int be = 0; be < 2; be++) begin
            big_endian = be[0];
            for (int lo = 0; lo < 4; lo++) begin
                access(1'b1, 32'h8000_0020 | lo, 2'b00, 32'h1122_3344 + lo * 32'h0101_0101 + be * 32'h4040_4040,
                       "R3 byte write");
                access(1'b0, 32'h8000_0004, 2'b10, 32'h0, "R3 R4 word view after byte write");
                access(1'b0, 32'h8000_0000 | lo, 2'b00, 32'h0, "R3 byte read back");
            end
        end
        big_endian = 1'b0;

        // Half-word write to GPIO: ignored, error flagged
        access(1'b1, 32'h8000_0002, 2'b01, 32'hFFFF_FFFF, "R5 half write");
        access(1'b0, 32'h8000_0000, 2'b10, 32'h0, "R5 ports unchanged");

        // Word write in big-endian mode equals little-endian layout
        big_endian = 1'b1;
        access(1'b1, 32'h8000_0001, 2'b10, 32'hCAFE_F00D, "R4 word write big endian");
        big_endian = 1'b0;
        access(1'b0, 32'h8000_0003, 2'b10, 32'h0, "R4 word read little endian");

        // Accesses outside the window
        access(1'b1, 32'h8000_4040, 2'b10, 32'hFFFF_FFFF, "R1 write above window");
        access(1'b1, 32'h7FFF_FFC0, 2'b10, 32'hFFFF_FFFF, "R1 write below window");
        access(1'b1, 32'h0000_0000, 2'b10, 32'hFFFF_FFFF, "R1 write low memory");
        access(1'b1, 32'hC000_0240, 2'b00, 32'hFFFF_FFFF, "R1 write alias high bit");
        access(1'b0, 32'h8000_4040, 2'b10, 32'h0, "R1 read above window");
        access(1'b0, 32'h0000_0000, 2'b10, 32'h0, "R1 read low memory");
        read_slots("R1 registers unchanged");

        // Ordinary registers: byte write loads whole word, undefined bits dropped
        big_endian = 1'b1;
        access(1'b1, 32'h8000_0043, 2'b00, 32'hFFFF_FFFF, "R6 byte write ordinary");
        access(1'b0, 32'h8000_007D, 2'b00, 32'h0, "R6 R7 byte read full register");
        access(1'b1, 32'h8000_0201, 2'b01, 32'h1234_5678, "R6 R7 half write refresh");
        access(1'b0, 32'h8000_0202, 2'b01, 32'h0, "R6 R7 refresh width");
        big_endian = 1'b0;

        // Idle cycle returns zero; back-to-back write then read
        @(negedge clk);
        check("R8 idle rdata", bus_rdata, 32'h0);
        access(1'b1, 32'h8000_0280, 2'b10, 32'h0BAD_BEEF, "R8 write");
        access(1'b0, 32'h8000_02BC, 2'b10, 32'h0, "R8 read next cycle");

        // Reset domains
        fill_all();
        do_reset(1'b1, 1'b0, 1'b1);
        read_slots("R10 after user reset");
        fill_all();
        do_reset(1'b1, 1'b1, 1'b0);
        read_slots("R10 after power-fail reset");
        fill_all();
        do_reset(1'b0, 1'b0, 1'b1);
        read_slots("R9 power-on with user reset");
        fill_all();
        do_reset(1'b0, 1'b1, 1'b1);
        read_slots("R9 power-on alone");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule